// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is the control side of a byte-wide parallel NOR flash, placed in front of a small register array. It watches bus cycles made of an address, a data byte and active-low chip, write and output enables, and sampled on the system clock. Write cycles feed a command decoder. The decoder recognises an unlock handshake, followed by a program command or by a sector erase command. While an erase runs, it also accepts suspend and resume commands.

Program and erase take a fixed number of clock cycles, set by parameters. While an operation is in flight, a read returns a status byte instead of array contents. A ready output goes low during the operation. A parameter can force every program to overrun its time limit, which lets the failure report be exercised.

The status byte is laid out as follows. Bit 7 is the polling bit. Bit 6 is the toggle bit. Bit 5 is the timeout flag. Bits 4 to 0 read as zero. The unlock handshake is AAh written at 555h, then 55h written at 2AAh. The array holds `WORDS` bytes, addressed by the low address bits, and is split into `SECTORS` equal sectors.

Top module: `flash_cmd_top`

## Requirements
- R1: Unlock, then A0h at 555h, then one more write programs that write's address with old AND data, so programming only clears bits; after `PROG_CYCLES` cycles the byte reads back.
- R2: A write that does not match the next expected step of a sequence returns the decoder to read mode; a later data write then leaves the array unchanged.
- R3: The program address is taken when write enable falls. The program data is taken when write enable rises, and that rise starts the operation.
- R4: While a program runs, status bit 7 reads the inverse of bit 7 of the programmed data; once the program is done, the array byte is returned.
- R5: Unlock, 80h at 555h, unlock again, then 30h at any address in a sector erases that sector. During the erase, status bit 7 reads 0. Afterwards every byte of that sector reads FFh, and other sectors are untouched.
- R6: During a program or erase, each read cycle inverts status bit 6. When the operation ends, repeated reads return identical data.
- R7: With `FORCE_TIMEOUT` set, a program never completes. Status bit 5 reads 1 and ready stays low until F0h is written, and the array is not changed.
- R8: B0h written during an erase suspends it. Ready goes high, reads return array data, and the remaining erase time is held.
- R9: 30h written outside the erase-suspended state has no effect. Written while suspended, it resumes the erase.
- R10: A program issued while an erase is suspended drives ready low while it runs. The block then returns to the suspended erase.
- R11: Ready is low while a program or erase runs, and during a failed program. It is high otherwise.
- R12: After reset, ready is high, the decoder is in read mode and every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; its falling edge is one read cycle |
| addr | input | 11 | Bus address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Array data, or the status byte while busy |
| ready | output | 1 | High when no program or erase is running |

## Verification
The assertions assume that the bus pins change only between clock edges and that each enable stays low for at least one full clock. They also assume that chip enable is low whenever write enable rises, and that a read and a write never overlap. The bench drives every pin on the falling clock edge and holds each write-enable phase for a whole cycle. It changes the address after write enable has fallen, so that the captured address is checked. It keeps the two instances apart by gating write enable, so that each instance sees only its own command stream.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BUS_AW = 11;
    localparam int DW     = 8;

    localparam logic [BUS_AW-1:0] UNL_ADDR_A = 11'h555;
    localparam logic [BUS_AW-1:0] UNL_ADDR_B = 11'h2AA;
    localparam logic [DW-1:0]     UNL_DATA_A = 8'hAA;
    localparam logic [DW-1:0]     UNL_DATA_B = 8'h55;
    localparam logic [DW-1:0]     CMD_PROG   = 8'hA0;
    localparam logic [DW-1:0]     CMD_EARM   = 8'h80;
    localparam logic [DW-1:0]     CMD_SECTOR = 8'h30;
    localparam logic [DW-1:0]     CMD_RESUME = 8'h30;
    localparam logic [DW-1:0]     CMD_SUSP   = 8'hB0;
    localparam logic [DW-1:0]     CMD_RESET  = 8'hF0;

    typedef enum logic [3:0] {
        FS_READ, FS_UNL1, FS_UNL2, FS_PSETUP,
        FS_EARM, FS_EUNL1, FS_EUNL2,
        FS_PBUSY, FS_EBUSY, FS_FAIL
    } fsm_t;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic [DW-1:0]     data;
    } bus_wr_t;

    function automatic logic [DW-1:0] status_byte(input logic poll, input logic tog, input logic tmo);
        return {poll, tog, tmo, 5'b0};
    endfunction

    function automatic logic wr_is(input bus_wr_t w, input logic [BUS_AW-1:0] a, input logic [DW-1:0] d);
        return (w.addr == a) && (w.data == d);
    endfunction

endpackage

// File: rtl/fcsm_bus_edge.sv
module fcsm_bus_edge
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic              wr_valid,
    output bus_wr_t           wr,
    output logic              rd_stb
);
    logic              we_q, oe_q;
    logic [BUS_AW-1:0] addr_lat;
    logic              we_fall;

    assign we_fall  = we_q & ~we_n & ~ce_n;
    assign wr_valid = ~we_q & we_n & ~ce_n;
    assign rd_stb   = oe_q & ~oe_n & ~ce_n & we_n;
    assign wr.addr  = addr_lat;
    assign wr.data  = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q     <= 1'b1;
            oe_q     <= 1'b1;
            addr_lat <= '0;
        end else begin
            we_q <= we_n;
            oe_q <= oe_n;
            if (we_fall) addr_lat <= addr;
        end
    end

    // address captured at the falling edge survives a changing bus (R3)
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!we_q && !we_n) |=> (addr_lat == $past(addr_lat)));

endmodule

// File: rtl/fcsm_ctrl.sv
module fcsm_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int WORDS         = 64,
    parameter int SECTORS       = 4,
    parameter int PROG_CYCLES   = 6,
    parameter int ERASE_CYCLES  = 40,
    parameter bit FORCE_TIMEOUT = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_valid,
    input  bus_wr_t                    wr,
    output fsm_t                       state_o,
    output logic                       susp_o,
    output logic                       prog_go,
    output logic [$clog2(WORDS)-1:0]   prog_idx,
    output logic [DW-1:0]              prog_data,
    output logic                       erase_go,
    output logic [$clog2(SECTORS)-1:0] erase_sec
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int SEC_W = $clog2(SECTORS);
    localparam int PCW   = $clog2(PROG_CYCLES + 1);
    localparam int ECW   = $clog2(ERASE_CYCLES + 1);

    fsm_t            state_q;
    logic            susp_q;
    logic [PCW-1:0]  pcnt_q;
    logic [ECW-1:0]  ecnt_q;
    logic [IDX_W-1:0] pidx_q;
    logic [DW-1:0]   pdata_q;
    logic [SEC_W-1:0] esec_q;

    assign state_o   = state_q;
    assign susp_o    = susp_q;
    assign prog_idx  = pidx_q;
    assign prog_data = pdata_q;
    assign erase_sec = esec_q;
    assign prog_go   = (state_q == FS_PBUSY) && (pcnt_q == '0) && !FORCE_TIMEOUT;
    assign erase_go  = (state_q == FS_EBUSY) && (ecnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_READ;
            susp_q  <= 1'b0;
            pcnt_q  <= '0;
            ecnt_q  <= '0;
            pidx_q  <= '0;
            pdata_q <= '1;
            esec_q  <= '0;
        end else begin
            unique case (state_q)
                FS_READ: if (wr_valid) begin
                    if (wr_is(wr, UNL_ADDR_A, UNL_DATA_A)) state_q <= FS_UNL1;
                    else if (susp_q && wr.data == CMD_RESUME) begin
                        state_q <= FS_EBUSY;
                        susp_q  <= 1'b0;
                    end
                end
                FS_UNL1: if (wr_valid)
                    state_q <= wr_is(wr, UNL_ADDR_B, UNL_DATA_B) ? FS_UNL2 : FS_READ;
                FS_UNL2: if (wr_valid) begin
                    if (wr_is(wr, UNL_ADDR_A, CMD_PROG)) state_q <= FS_PSETUP;
                    else if (!susp_q && wr_is(wr, UNL_ADDR_A, CMD_EARM)) state_q <= FS_EARM;
                    else state_q <= FS_READ;
                end
                FS_PSETUP: if (wr_valid) begin
                    pidx_q  <= wr.addr[IDX_W-1:0];
                    pdata_q <= wr.data;
                    pcnt_q  <= PCW'(PROG_CYCLES - 1);
                    state_q <= FS_PBUSY;
                end
                FS_EARM: if (wr_valid)
                    state_q <= wr_is(wr, UNL_ADDR_A, UNL_DATA_A) ? FS_EUNL1 : FS_READ;
                FS_EUNL1: if (wr_valid)
                    state_q <= wr_is(wr, UNL_ADDR_B, UNL_DATA_B) ? FS_EUNL2 : FS_READ;
                FS_EUNL2: if (wr_valid) begin
                    if (wr.data == CMD_SECTOR) begin
                        esec_q  <= wr.addr[IDX_W-1 -: SEC_W];
                        ecnt_q  <= ECW'(ERASE_CYCLES - 1);
                        state_q <= FS_EBUSY;
                    end else begin
                        state_q <= FS_READ;
                    end
                end
                FS_PBUSY: begin
                    if (pcnt_q == '0) state_q <= FORCE_TIMEOUT ? FS_FAIL : FS_READ;
                    else pcnt_q <= pcnt_q - 1'b1;
                end
                FS_EBUSY: begin
                    if (ecnt_q == '0) state_q <= FS_READ;
                    else if (wr_valid && wr.data == CMD_SUSP) begin
                        state_q <= FS_READ;
                        susp_q  <= 1'b1;
                    end else ecnt_q <= ecnt_q - 1'b1;
                end
                FS_FAIL: if (wr_valid && wr.data == CMD_RESET) state_q <= FS_READ;
                default: state_q <= FS_READ;
            endcase
        end
    end

    p_prog_finish_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_PBUSY && pcnt_q == '0 && !FORCE_TIMEOUT) |=> (state_q == FS_READ));

    p_fail_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_FAIL && !(wr_valid && wr.data == CMD_RESET)) |=> (state_q == FS_FAIL));

    p_erase_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == FS_READ && susp_q) |=> (ecnt_q == $past(ecnt_q)));

    p_resume_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr.data == CMD_RESUME && state_q == FS_READ && !susp_q)
        |=> (state_q == FS_READ && !susp_q));

endmodule

// File: rtl/fcsm_array.sv
module fcsm_array
    import flash_cmd_pkg::*;
#(
    parameter int WORDS   = 64,
    parameter int SECTORS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       prog_go,
    input  logic [$clog2(WORDS)-1:0]   prog_idx,
    input  logic [DW-1:0]              prog_data,
    input  logic                       erase_go,
    input  logic [$clog2(SECTORS)-1:0] erase_sec,
    input  logic [$clog2(WORDS)-1:0]   rd_idx,
    output logic [DW-1:0]              rd_word
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int SEC_W = $clog2(SECTORS);
    localparam int WPS   = WORDS / SECTORS;

    logic [DW-1:0]    mem [WORDS];
    logic [IDX_W-1:0] esec_first;

    assign rd_word    = mem[rd_idx];
    assign esec_first = {erase_sec, {(IDX_W-SEC_W){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (erase_go) begin
            for (int i = 0; i < WORDS; i++)
                if (SEC_W'(i / WPS) == erase_sec) mem[i] <= '1;
        end else if (prog_go) begin
            mem[prog_idx] <= mem[prog_idx] & prog_data;
        end
    end

    p_prog_clears_r1: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> ((mem[prog_idx] & ~$past(mem[prog_idx])) == '0));

    p_erase_fills_r5: assert property (@(posedge clk) disable iff (rst)
        erase_go |=> (mem[esec_first] == '1));

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
    import flash_cmd_pkg::*;
#(
    parameter int WORDS         = 64,
    parameter int SECTORS       = 4,
    parameter int PROG_CYCLES   = 6,
    parameter int ERASE_CYCLES  = 40,
    parameter bit FORCE_TIMEOUT = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic        oe_n,
    input  logic [10:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        ready
);
    localparam int IDX_W = $clog2(WORDS);
    localparam int SEC_W = $clog2(SECTORS);

    logic             wr_valid, rd_stb;
    bus_wr_t          wr;
    fsm_t             state;
    logic             susp;
    logic             prog_go, erase_go;
    logic [IDX_W-1:0] prog_idx;
    logic [DW-1:0]    prog_data, rd_word;
    logic [SEC_W-1:0] erase_sec;
    logic             busy_p, busy_e, toggle_q;

    fcsm_bus_edge u_edge (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .wr_valid(wr_valid), .wr(wr), .rd_stb(rd_stb)
    );

    fcsm_ctrl #(
        .WORDS(WORDS), .SECTORS(SECTORS), .PROG_CYCLES(PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES), .FORCE_TIMEOUT(FORCE_TIMEOUT)
    ) u_ctrl (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr(wr),
        .state_o(state), .susp_o(susp), .prog_go(prog_go), .prog_idx(prog_idx),
        .prog_data(prog_data), .erase_go(erase_go), .erase_sec(erase_sec)
    );

    fcsm_array #(.WORDS(WORDS), .SECTORS(SECTORS)) u_array (
        .clk(clk), .rst(rst), .prog_go(prog_go), .prog_idx(prog_idx),
        .prog_data(prog_data), .erase_go(erase_go), .erase_sec(erase_sec),
        .rd_idx(addr[IDX_W-1:0]), .rd_word(rd_word)
    );

    assign busy_p = (state == FS_PBUSY) || (state == FS_FAIL);
    assign busy_e = (state == FS_EBUSY);
    assign ready  = !(busy_p || busy_e);

    always_ff @(posedge clk) begin
        if (rst) toggle_q <= 1'b0;
        else if (rd_stb && (busy_p || busy_e)) toggle_q <= ~toggle_q;
    end

    always_comb begin
        if (busy_p)      rdata = status_byte(~prog_data[7], toggle_q, state == FS_FAIL);
        else if (busy_e) rdata = status_byte(1'b0, toggle_q, 1'b0);
        else             rdata = rd_word;
    end

    p_toggle_flip_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !ready) |=> (toggle_q != $past(toggle_q)));

    p_toggle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ready |=> $stable(toggle_q));

    p_ready_suspended_r8: assert property (@(posedge clk) disable iff (rst)
        (state == FS_READ && susp) |-> ready);

    p_no_go_overlap_r11: assert property (@(posedge clk) disable iff (rst)
        $countones({prog_go, erase_go}) <= 1);

endmodule

// File: tb/flash_cmd_top_bench.sv
module flash_cmd_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic        tmo_sel = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata_m, rdata_t;
    logic        ready_m, ready_t;
    logic        done = 1'b0;
    int          n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    flash_cmd_top u_flash_cmd_top (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n | tmo_sel), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata_m), .ready(ready_m)
    );

    flash_cmd_top #(.FORCE_TIMEOUT(1'b1)) u_flash_cmd_top_tmo (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n | ~tmo_sel), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata_t), .ready(ready_t)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = ~d; we_n = 1'b0;
        @(negedge clk); addr = ~a; wdata = d;   // R3: address must already be latched
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [10:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; oe_n = 1'b0;
        @(negedge clk); v = tmo_sel ? rdata_t : rdata_m; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock_prog(input logic [10:0] a, input logic [7:0] d);
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'hA0); bus_wr(a, d);
    endtask

    // {op, req, addr, data, expected}; op 0 write, 1 read+check, 2 idle(data cycles)
    localparam int NV = 21;
    localparam logic [32:0] VEC [NV] = '{
        {2'd0, 4'd1, 11'h555, 8'hAA, 8'h00},
        {2'd0, 4'd1, 11'h2AA, 8'h55, 8'h00},
        {2'd0, 4'd1, 11'h555, 8'hA0, 8'h00},
        {2'd0, 4'd1, 11'h010, 8'h5A, 8'h00},
        {2'd2, 4'd1, 11'h000, 8'd12, 8'h00},
        {2'd1, 4'd1, 11'h010, 8'h00, 8'h5A},
        {2'd1, 4'd1, 11'h011, 8'h00, 8'hFF},
        {2'd0, 4'd1, 11'h555, 8'hAA, 8'h00},
        {2'd0, 4'd1, 11'h2AA, 8'h55, 8'h00},
        {2'd0, 4'd1, 11'h555, 8'hA0, 8'h00},
        {2'd0, 4'd1, 11'h010, 8'h0F, 8'h00},
        {2'd2, 4'd1, 11'h000, 8'd12, 8'h00},
        {2'd1, 4'd1, 11'h010, 8'h00, 8'h0A},
        {2'd0, 4'd2, 11'h555, 8'hAA, 8'h00},
        {2'd0, 4'd2, 11'h2AA, 8'h12, 8'h00},
        {2'd0, 4'd2, 11'h555, 8'hA0, 8'h00},
        {2'd0, 4'd2, 11'h020, 8'h00, 8'h00},
        {2'd2, 4'd2, 11'h000, 8'd12, 8'h00},
        {2'd1, 4'd2, 11'h020, 8'h00, 8'hFF},
        {2'd0, 4'd9, 11'h123, 8'h30, 8'h00},
        {2'd1, 4'd9, 11'h010, 8'h00, 8'h0A}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] s1, s2;
        idle(3);
        rst = 1'b0; ce_n = 1'b0;
        idle(2);
        // R12: reset state
        check("R12 ready after reset", {7'b0, ready_m}, 8'h01);
        bus_rd(11'h000, s1); check("R12 erased byte", s1, 8'hFF);

        // vector walk: R1 R2 R3 R9
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [10:0] a;
            logic [7:0]  d, e;
            {op, rq, a, d, e} = VEC[i];
            if (op == 2'd0) bus_wr(a, d);
            else if (op == 2'd2) idle(int'(d));
            else begin
                bus_rd(a, s1);
                check($sformatf("R%0d/R3 vector %0d", rq, i), s1, e);
            end
        end
        check("R9 ready after stray resume", {7'b0, ready_m}, 8'h01);

        // R4 R6 R11: program polling
        unlock_prog(11'h02C, 8'h7F);
        check("R11 busy during program", {7'b0, ready_m}, 8'h00);
        bus_rd(11'h000, s1); bus_rd(11'h02C, s2);
        check("R4 polling bit inverted", {7'b0, s1[7]}, 8'h01);
        check("R6 toggle differs", {7'b0, s1[6] ^ s2[6]}, 8'h01);
        idle(12);
        check("R11 ready after program", {7'b0, ready_m}, 8'h01);
        bus_rd(11'h02C, s1); bus_rd(11'h02C, s2);
        check("R4 true data after program", s1, 8'h7F);
        check("R6 toggle stops", s2, s1);

        // R5 R8 R10 R9: sector erase with suspend
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h555, 8'h80);
        bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h55); bus_wr(11'h01F, 8'h30);
        check("R11 busy during erase", {7'b0, ready_m}, 8'h00);
        bus_rd(11'h000, s1);
        check("R5 erase polling bit", {7'b0, s1[7]}, 8'h00);
        bus_wr(11'h000, 8'hB0);
        check("R8 ready while suspended", {7'b0, ready_m}, 8'h01);
        bus_rd(11'h010, s1); check("R8 array data while suspended", s1, 8'h0A);
        unlock_prog(11'h030, 8'h33);
        check("R10 busy program in suspend", {7'b0, ready_m}, 8'h00);
        idle(12);
        check("R10 back to suspended", {7'b0, ready_m}, 8'h01);
        bus_rd(11'h030, s1); check("R10 programmed in suspend", s1, 8'h33);
        idle(60);
        bus_rd(11'h010, s1); check("R8 erase held", s1, 8'h0A);
        bus_wr(11'h000, 8'h30);
        check("R9 resume restarts erase", {7'b0, ready_m}, 8'h00);
        idle(60);
        check("R11 ready after erase", {7'b0, ready_m}, 8'h01);
        bus_rd(11'h010, s1); check("R5 sector first byte", s1, 8'hFF);
        bus_rd(11'h01F, s1); check("R5 sector last byte", s1, 8'hFF);
        bus_rd(11'h030, s1); check("R5 other sector kept", s1, 8'h33);
        bus_rd(11'h02C, s1); check("R5 other sector kept", s1, 8'h7F);

        // R7: forced program timeout on second instance
        tmo_sel = 1'b1;
        unlock_prog(11'h005, 8'h00);
        idle(12);
        check("R7 busy held on timeout", {7'b0, ready_t}, 8'h00);
        bus_rd(11'h005, s1);
        check("R7 timeout flag", {7'b0, s1[5]}, 8'h01);
        bus_wr(11'h000, 8'hF0);
        check("R7 ready after reset command", {7'b0, ready_t}, 8'h01);
        bus_rd(11'h005, s1); check("R7 array untouched", s1, 8'hFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule